// File: doc/BRIEF.md
# GCI Control-Channel Handler

This block handles the control side of one slave on a GCI highway. A serial front end delivers each subframe of the frame as parallel byte fields, one strobe per subframe, together with the subframe's index. The block acts only on the subframe whose index matches its three strap pins. All other subframes leave it untouched.

From the downstream monitor byte and the handshake bits of the SC byte, the block collects a short register-access message. The message is a command byte, an address byte and, for writes, a data byte. Further address/data pairs may follow a write command. Each accepted write or read is issued as a one-cycle strobe on a simple register port. For a read, the register value is returned upstream in the monitor byte once the host has closed its message. The block aborts a transfer on a malformed command, an out-of-range address, a broken handshake or a collision. The same SC byte carries the command/indicate bits, which are debounced on the way in. On the way out, status flags are placed in those bits and each change is held for a minimum period.

Top module: `gci_ctl_port`

## Requirements
- R1: Only subframe strobes whose `frame_slot` equals `slot_strap` have any effect. A strobe for any other slot changes no output and no internal state.
- R2: When the block is not sending a reply or an abort, `up_mon` is 0xFF and the upstream handshake bits MX (`up_sc[1]`) and MR (`up_sc[0]`) are both 1, which is their inactive level. `up_sc[7]` is always 0.
- R3: A downstream monitor byte counts as received only when it arrives with MX low (`dn_sc[1]`=0) in two consecutive own frames. It is acknowledged by driving MR low from that frame until the host raises MX.
- R4: A command byte whose bits 6:0 equal 0000001 and whose bit 7 is 0 starts a write. Each following address byte and data byte pair produces exactly one `reg_wr` pulse, one cycle after the frame that confirmed the data byte, with `reg_addr` and `reg_wdata` holding that pair.
- R5: A command byte of 0x81 followed by an address byte produces one `reg_rd` pulse. After the host holds MX high for two consecutive frames (end of message), the block sends the value read in `up_mon` with MX low. It keeps sending until the host drives MR low. It then holds MX high and `up_mon` at 0xFF for two frames and returns to idle.
- R6: If bits 6:0 of the command byte differ from 0000001, the block aborts and performs no register access.
- R7: An address byte of `NUM_REGS` (60 by default) or above causes an abort. Writes already completed in the same message stay done.
- R8: If MX goes high after the first copy of a byte but before the second, confirming copy, the block aborts.
- R9: While sending a reply, any downstream monitor byte other than 0xFF is a collision and causes an abort.
- R10: An abort drives MX and MR both low, with `up_mon` at 0xFF, for two frames. The block then returns to idle and ignores downstream traffic during those two frames.
- R11: The incoming C/I bits (`dn_sc[7:2]`) update `ci_rx` only when the same value has arrived in two consecutive own frames. A one-frame glitch is not latched.
- R12: `up_sc[6:2]` carries `stat_in[4:0]`, which holds the flags in this order from `stat_in[4]` to `stat_in[0]`: status valid, drop-out, interrupt, battery polarity, tip-ground. A change is sampled at an own frame. Once changed, the outgoing value is held for at least two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_strap | input | 3 | Strap selecting the own subframe |
| frame_stb | input | 1 | One-cycle strobe: subframe fields are valid |
| frame_slot | input | 3 | Index of the subframe being presented |
| dn_mon | input | 8 | Downstream monitor byte |
| dn_sc | input | 8 | Downstream SC byte: C/I in 7:2, MX in 1, MR in 0 |
| stat_in | input | 5 | Status flags for the upstream C/I bits |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |
| up_mon | output | 8 | Upstream monitor byte |
| up_sc | output | 8 | Upstream SC byte: reserved 7, C/I 6:2, MX 1, MR 0 |
| ci_rx | output | 6 | Debounced incoming C/I value |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |

## Verification
Every monitor-channel and C/I result is registered at the clock edge that takes an own-slot strobe, so it is visible in the cycle that follows. `reg_wr` and `reg_rd` rise one cycle after the confirming strobe. The read value is captured one cycle after that. Each bench frame holds the strobe for one cycle and then idles for two cycles before sampling at a falling edge, so every one of these results has settled. Access strobes are counted by a posedge monitor running alongside the frames.

// File: rtl/gci_ctl_port.sv
module gci_ctl_port #(
  parameter int          NUM_REGS     = 60,
  parameter int          ABORT_FRAMES = 2,
  parameter logic [6:0]  CMD_REG      = 7'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] slot_strap,
  input  logic       frame_stb,
  input  logic [2:0] frame_slot,
  input  logic [7:0] dn_mon,
  input  logic [7:0] dn_sc,
  input  logic [4:0] stat_in,
  input  logic [7:0] reg_rdata,
  output logic [7:0] up_mon,
  output logic [7:0] up_sc,
  output logic [5:0] ci_rx,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata
);
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam int         CW        = $clog2(ABORT_FRAMES + 2);
  localparam logic [CW-1:0] ABT_LAST = CW'(ABORT_FRAMES - 1);
  localparam logic [CW-1:0] EOM_LAST = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_HAVE1, S_DONE, S_SEP, S_TX, S_TXEND, S_ABORT} st_t;

  st_t           st;
  logic [7:0]    cand;
  logic [1:0]    idx;
  logic          is_rd;
  logic [CW-1:0] cnt;
  logic [7:0]    resp;
  logic          resp_ok;
  logic [5:0]    ci_cand;
  logic [4:0]    ci_tx;
  logic [1:0]    ci_age;

  wire       ev     = frame_stb && (frame_slot == slot_strap);
  wire       mx_dn  = dn_sc[1];
  wire       mr_dn  = dn_sc[0];
  wire [5:0] ci_dn  = dn_sc[7:2];
  wire       addr_bad = int'(dn_mon) >= NUM_REGS;

  wire up_mx = !(st == S_TX || st == S_ABORT);
  wire up_mr = !(st == S_DONE || st == S_ABORT);

  assign up_mon = (st == S_TX) ? resp : IDLE_BYTE;
  assign up_sc  = {1'b0, ci_tx, up_mx, up_mr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cand      <= IDLE_BYTE;
      idx       <= '0;
      is_rd     <= 1'b0;
      cnt       <= '0;
      resp      <= IDLE_BYTE;
      resp_ok   <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      ci_cand   <= '0;
      ci_rx     <= '0;
      ci_tx     <= '0;
      ci_age    <= 2'd2;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_rd) begin
        resp    <= reg_rdata;
        resp_ok <= 1'b1;
      end
      if (ev) begin
        ci_cand <= ci_dn;
        if (ci_dn == ci_cand) ci_rx <= ci_dn;

        if (stat_in != ci_tx && ci_age == 2'd2) begin
          ci_tx  <= stat_in;
          ci_age <= 2'd1;
        end else if (ci_age != 2'd2) begin
          ci_age <= ci_age + 2'd1;
        end

        case (st)
          S_IDLE: if (!mx_dn) begin
            cand <= dn_mon;
            idx  <= '0;
            st   <= S_HAVE1;
          end
          S_HAVE1: begin
            if (mx_dn) begin
              st <= S_ABORT; cnt <= '0; resp_ok <= 1'b0;
            end else if (dn_mon != cand) begin
              cand <= dn_mon;
            end else begin
              st <= S_DONE;
              case (idx)
                2'd0: begin
                  if (dn_mon[6:0] != CMD_REG) begin
                    st <= S_ABORT; cnt <= '0; resp_ok <= 1'b0;
                  end else begin
                    is_rd <= dn_mon[7];
                    idx   <= 2'd1;
                  end
                end
                2'd1: begin
                  if (addr_bad) begin
                    st <= S_ABORT; cnt <= '0; resp_ok <= 1'b0;
                  end else begin
                    reg_addr <= dn_mon;
                    if (is_rd) begin
                      reg_rd <= 1'b1;
                      idx    <= 2'd3;
                    end else begin
                      idx    <= 2'd2;
                    end
                  end
                end
                2'd2: begin
                  reg_wdata <= dn_mon;
                  reg_wr    <= 1'b1;
                  idx       <= 2'd1;
                end
                default: begin
                  st <= S_ABORT; cnt <= '0; resp_ok <= 1'b0;
                end
              endcase
            end
          end
          S_DONE: if (mx_dn) st <= S_SEP;
          S_SEP: begin
            if (!mx_dn) begin
              cand <= dn_mon;
              st   <= S_HAVE1;
            end else begin
              st <= resp_ok ? S_TX : S_IDLE;
            end
          end
          S_TX: begin
            if (dn_mon != IDLE_BYTE) begin
              st <= S_ABORT; cnt <= '0; resp_ok <= 1'b0;
            end else if (!mr_dn) begin
              st <= S_TXEND; cnt <= '0; resp_ok <= 1'b0;
            end
          end
          S_TXEND: begin
            if (cnt == EOM_LAST) st <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
          S_ABORT: begin
            if (cnt == ABT_LAST) st <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gci_ctl_port_chk.sv
module gci_ctl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] slot_strap,
  input logic       frame_stb,
  input logic [2:0] frame_slot,
  input logic [7:0] up_mon,
  input logic [7:0] up_sc,
  input logic [5:0] ci_rx,
  input logic       reg_wr,
  input logic       reg_rd
);
  wire own_ev = frame_stb && (frame_slot == slot_strap);

  // R2
  idle_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_sc[1] |-> up_mon == 8'hFF);

  // R2
  rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_ev |=> up_sc[7] == 1'b0);

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R4
  acc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R1
  wr_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr) |-> $past(own_ev));

  // R10
  abort_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_sc[1] && !up_sc[0]) |-> up_mon == 8'hFF);

  // R11
  ci_rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_ev |=> $stable(ci_rx));

  // R12
  ci_tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_ev |=> $stable(up_sc[6:2]));
endmodule

bind gci_ctl_port gci_ctl_port_chk u_chk (.*);

// File: tb/gci_ctl_port_bench.sv
module gci_ctl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] STRAP = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [2:0] frame_slot = '0;
  logic [7:0] dn_mon = 8'hFF;
  logic [7:0] dn_sc = 8'h03;
  logic [4:0] stat_in = '0;
  logic [7:0] reg_rdata;
  logic [7:0] up_mon, up_sc, reg_addr, reg_wdata;
  logic [5:0] ci_rx;
  logic       reg_wr, reg_rd;

  logic [5:0] ci_cur = '0;
  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_wa = '0, last_wd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign reg_rdata = reg_addr ^ 8'hA5;

  gci_ctl_port u_gci_ctl_port (
    .clk(clk), .rst_n(rst_n), .slot_strap(STRAP), .frame_stb(frame_stb),
    .frame_slot(frame_slot), .dn_mon(dn_mon), .dn_sc(dn_sc), .stat_in(stat_in),
    .reg_rdata(reg_rdata), .up_mon(up_mon), .up_sc(up_sc), .ci_rx(ci_rx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= reg_wdata;
    end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic frame_at(input logic [2:0] slot, input logic [7:0] mon,
                          input logic mx, input logic mr);
    @(negedge clk);
    frame_slot = slot;
    dn_mon     = mon;
    dn_sc      = {ci_cur, mx, mr};
    frame_stb  = 1'b1;
    @(negedge clk);
    frame_stb  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] mon, input logic mx, input logic mr);
    frame_at(STRAP, mon, mx, mr);
  endtask

  task automatic send_byte(input logic [7:0] b);
    frame(b, 1'b0, 1'b1);
    frame(b, 1'b0, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_reset;
    chk("R2 reset up_mon", up_mon, 8'hFF);
    chk("R2 reset up_sc", up_sc, 8'h03);
    chk("R11 reset ci_rx", ci_rx, 6'h00);
    chk("R4 reset no write", wr_cnt, 0);
  endtask

  task automatic t_ci_rx;
    ci_cur = 6'h2A;
    frame(8'hFF, 1'b1, 1'b1);
    chk("R11 one frame not latched", ci_rx, 6'h00);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R11 two frames latched", ci_rx, 6'h2A);
    ci_cur = 6'h15;
    frame(8'hFF, 1'b1, 1'b1);
    chk("R11 glitch frame held", ci_rx, 6'h2A);
    ci_cur = 6'h2A;
    frame(8'hFF, 1'b1, 1'b1);
    chk("R11 glitch ignored", ci_rx, 6'h2A);
  endtask

  task automatic t_slot;
    ci_cur = 6'h11;
    stat_in = 5'b11111;
    frame_at(3'd2, 8'h01, 1'b0, 1'b1);
    frame_at(3'd2, 8'h01, 1'b0, 1'b1);
    chk("R1 other slot ci_rx", ci_rx, 6'h2A);
    chk("R1 other slot no ack", up_sc[1:0], 2'b11);
    chk("R1 other slot no ci_tx", up_sc[6:2], 5'b00000);
    ci_cur = 6'h2A;
    stat_in = 5'b00000;
    frame(8'hFF, 1'b1, 1'b1);
    chk("R1 own slot idle after", up_sc[1:0], 2'b11);
  endtask

  task automatic t_ci_tx;
    stat_in = 5'b10110;
    frame(8'hFF, 1'b1, 1'b1);
    chk("R12 status sent", up_sc[6:2], 5'b10110);
    stat_in = 5'b00001;
    frame(8'hFF, 1'b1, 1'b1);
    chk("R12 change held", up_sc[6:2], 5'b10110);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R12 change after hold", up_sc[6:2], 5'b00001);
    chk("R2 reserved bit", up_sc[7], 1'b0);
  endtask

  task automatic t_write;
    int w0 = wr_cnt;
    frame(8'h01, 1'b0, 1'b1);
    chk("R3 single copy no ack", up_sc[0], 1'b1);
    frame(8'h01, 1'b0, 1'b1);
    chk("R3 confirmed ack MR low", up_sc[0], 1'b0);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R3 ack released", up_sc[0], 1'b1);
    send_byte(8'h05);
    send_byte(8'h5A);
    chk("R4 first write count", wr_cnt, w0 + 1);
    chk("R4 first write addr", last_wa, 8'h05);
    chk("R4 first write data", last_wd, 8'h5A);
    send_byte(8'h06);
    send_byte(8'hC3);
    chk("R4 second write count", wr_cnt, w0 + 2);
    chk("R4 second write addr", last_wa, 8'h06);
    chk("R4 second write data", last_wd, 8'hC3);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R2 idle after write", {up_mon, up_sc[1:0]}, {8'hFF, 2'b11});
  endtask

  task automatic t_read;
    int r0 = rd_cnt;
    send_byte(8'h81);
    send_byte(8'h07);
    chk("R5 read strobe", rd_cnt, r0 + 1);
    chk("R5 no reply before end", up_sc[1], 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R5 reply byte", up_mon, 8'hA2);
    chk("R5 reply handshake", up_sc[1:0], 2'b01);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R5 reply held", up_mon, 8'hA2);
    frame(8'hFF, 1'b1, 1'b0);
    chk("R5 after host ack", {up_mon, up_sc[1:0]}, {8'hFF, 2'b11});
    frame(8'h01, 1'b0, 1'b1);
    frame(8'h01, 1'b0, 1'b1);
    chk("R5 ignored during end frames", up_sc[0], 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R5 back to idle", {up_mon, up_sc[1:0]}, {8'hFF, 2'b11});
  endtask

  task automatic t_badcmd;
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    frame(8'h02, 1'b0, 1'b1);
    frame(8'h02, 1'b0, 1'b1);
    chk("R6 abort on bad command", {up_mon, up_sc[1:0]}, {8'hFF, 2'b00});
    frame(8'hFF, 1'b1, 1'b1);
    chk("R10 abort second frame", up_sc[1:0], 2'b00);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R10 idle after abort", up_sc[1:0], 2'b11);
    chk("R6 no write", wr_cnt, w0);
    chk("R6 no read", rd_cnt, r0);
  endtask

  task automatic t_badaddr;
    int w0 = wr_cnt;
    send_byte(8'h01);
    send_byte(8'h09);
    send_byte(8'h77);
    frame(8'h40, 1'b0, 1'b1);
    frame(8'h40, 1'b0, 1'b1);
    chk("R7 abort on bad address", up_sc[1:0], 2'b00);
    chk("R7 earlier write kept", wr_cnt, w0 + 1);
    chk("R7 earlier write data", {last_wa, last_wd}, {8'h09, 8'h77});
    frame(8'hFF, 1'b1, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R10 idle after address abort", up_sc[1:0], 2'b11);
  endtask

  task automatic t_mxdrop;
    frame(8'h01, 1'b0, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R8 abort on early MX release", up_sc[1:0], 2'b00);
    frame(8'hFF, 1'b1, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R8 idle after abort", up_sc[1:0], 2'b11);
  endtask

  task automatic t_collide;
    send_byte(8'h81);
    send_byte(8'h03);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R9 reply byte", up_mon, 8'hA6);
    frame(8'h12, 1'b1, 1'b1);
    chk("R9 collision abort", {up_mon, up_sc[1:0]}, {8'hFF, 2'b00});
    frame(8'hFF, 1'b1, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R10 idle after collision", up_sc[1:0], 2'b11);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ci_rx();
    t_slot();
    t_ci_tx();
    t_write();
    t_read();
    t_badcmd();
    t_badaddr();
    t_mxdrop();
    t_collide();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule